// File: doc/BRIEF.md
# Aligned Register-Group Operation Expander

This block sits between instruction decode and the register file/ALU path. A decoded register-to-register operation arrives as one request: a source index, a destination index, an opcode, an incoming carry and a slot number. Each of the two operation slots has its own fan-out enable. When fan-out is allowed, the block repeats the operation on the next register pairs. It stops at the last register of the aligned block of four that holds the starting source index.

The number of beats depends on the low two bits of the indices. An offset of zero gives four beats, one gives three, two gives two and three gives one. When the low bits of source and destination disagree, or the slot's enable is clear, exactly one plain beat is issued. Beats leave one per clock with both indices stepping by one. For the carry-consuming opcodes, the ALU's carry-out of each beat becomes the carry-in of the next, so a multiword add or subtract spans the group.

Top module: `grp_ext_seq`

## Requirements
- R1: After reset, busy, issue_valid, issue_last and done are all 0.
- R2: A request is taken only on a clock edge where busy is 0. A request presented while busy is 1 changes no output, and the beats in flight continue unchanged.
- R3: With fan-out allowed, equal low index bits and low bits 00, four beats issue on consecutive cycles with source and destination indices start+0, +1, +2, +3.
- R4: With fan-out allowed and equal low bits, offset 01 gives three beats, offset 10 gives two beats and offset 11 gives one beat. No beat crosses into the next group of four.
- R5: When the low two bits of source and destination differ, exactly one beat issues, even when fan-out is allowed.
- R6: When the selected slot's enable is 0, exactly one beat issues for any index pair.
- R7: req_slot = 0 selects req_ext_en[0] and req_slot = 1 selects req_ext_en[1] as the fan-out enable.
- R8: The first beat appears in the cycle after acceptance. Beats follow one per cycle and all carry the request's opcode. issue_last is 1 only on the final beat, and busy equals issue_valid.
- R9: done is 1 for exactly the one cycle after the final beat, and busy is 0 in that cycle. A request held during that cycle is accepted at its closing edge.
- R10: The first beat's issue_cin is req_cin. For opcodes 6'h05 (add with carry) and 6'h07 (subtract with borrow), each later beat's issue_cin equals the alu_cout seen during the previous beat. For other opcodes, every beat carries req_cin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_src | input | 16 | Source register index |
| req_dst | input | 16 | Destination register index |
| req_op | input | 6 | Opcode |
| req_slot | input | 1 | Operation slot number (0 or 1) |
| req_ext_en | input | 2 | Per-slot fan-out enable |
| req_cin | input | 1 | Carry-in for the first beat |
| alu_cout | input | 1 | ALU carry-out for the beat now issued |
| busy | output | 1 | Group in progress; requests ignored |
| issue_valid | output | 1 | A beat is issued this cycle |
| issue_src | output | 16 | Source index of the beat |
| issue_dst | output | 16 | Destination index of the beat |
| issue_op | output | 6 | Opcode of the beat |
| issue_cin | output | 1 | Carry-in of the beat |
| issue_last | output | 1 | Final beat of the group |
| done | output | 1 | One-cycle pulse after the final beat |

## Verification
The completion pulse for one group and the acceptance of the next request share a cycle. In that cycle done is high, busy is low and a held request is taken at the closing edge. The bench provokes this by raising a second request while the first group is still issuing and keeping it raised until it is taken. A queue-based reference model then predicts, cycle by cycle, done high with the new group's first beat following immediately, and also that the request was not taken earlier while busy was high.

// File: rtl/grp_seq_pkg.sv
package grp_seq_pkg;
  localparam int GRP_LOG2 = 2;
  localparam int GRP_SIZE = 1 << GRP_LOG2;
  localparam int LEN_W    = GRP_LOG2 + 1;

  // Beats from a start offset to the end of its aligned group
  function automatic logic [LEN_W-1:0] span_len(
    input logic [GRP_LOG2-1:0] s_lo,
    input logic [GRP_LOG2-1:0] d_lo,
    input logic                fan_en
  );
    logic [LEN_W-1:0] n;
    if (fan_en && (s_lo == d_lo))
      n = LEN_W'(GRP_SIZE) - {1'b0, s_lo};
    else
      n = LEN_W'(1);
    return n;
  endfunction

  function automatic logic carries_chain(
    input logic [5:0] op,
    input logic [5:0] adc_code,
    input logic [5:0] sbb_code
  );
    return (op == adc_code) || (op == sbb_code);
  endfunction
endpackage

// File: rtl/grp_span_calc.sv
module grp_span_calc
  import grp_seq_pkg::*;
#(
  parameter int IDX_W  = 16,
  parameter int NSLOT  = 2,
  localparam int SEL_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IDX_W-1:0]     src,
  input  logic [IDX_W-1:0]     dst,
  input  logic [SEL_W-1:0]     slot,
  input  logic [NSLOT-1:0]     ext_en,
  output logic                 fan_en,
  output logic [LEN_W-1:0]     len
);
  logic [NSLOT-1:0] slot_hit;

  genvar g;
  generate
    for (g = 0; g < NSLOT; g++) begin : g_slot
      assign slot_hit[g] = (slot == SEL_W'(g)) && ext_en[g];
    end
  endgenerate

  assign fan_en = |slot_hit;
  assign len    = span_len(src[GRP_LOG2-1:0], dst[GRP_LOG2-1:0], fan_en);

  // R4
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (len >= LEN_W'(1)) && (len <= LEN_W'(GRP_SIZE)));
  // R5
  misalign_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src[GRP_LOG2-1:0] != dst[GRP_LOG2-1:0]) |-> (len == LEN_W'(1)));
endmodule

// File: rtl/grp_carry_link.sv
module grp_carry_link
  import grp_seq_pkg::*;
#(
  parameter int          OP_W     = 6,
  parameter logic [5:0]  ADC_CODE = 6'h05,
  parameter logic [5:0]  SBB_CODE = 6'h07
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            load_cin,
  input  logic [OP_W-1:0] op,
  input  logic            step_more,
  input  logic            alu_cout,
  output logic            cin
);
  logic cin_q;
  logic chain_op;

  assign chain_op = carries_chain(6'(op), ADC_CODE, SBB_CODE);

  always_ff @(posedge clk) begin
    if (!rst_n)                     cin_q <= 1'b0;
    else if (load)                  cin_q <= load_cin;
    else if (step_more && chain_op) cin_q <= alu_cout;
  end

  assign cin = cin_q;

  // R10
  carry_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_more && chain_op) |=> (cin == $past(alu_cout)));
  // R10
  carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_more && !chain_op) |=> $stable(cin));
endmodule

// File: rtl/grp_beat_ctrl.sv
module grp_beat_ctrl
  import grp_seq_pkg::*;
#(
  parameter int IDX_W = 16,
  parameter int OP_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [IDX_W-1:0] src,
  input  logic [IDX_W-1:0] dst,
  input  logic [OP_W-1:0]  op,
  input  logic [LEN_W-1:0] len,
  output logic             accept,
  output logic             busy,
  output logic [IDX_W-1:0] cur_src,
  output logic [IDX_W-1:0] cur_dst,
  output logic [OP_W-1:0]  cur_op,
  output logic             last,
  output logic             step_more,
  output logic             done
);
  logic             busy_q, done_q;
  logic [IDX_W-1:0] src_q, dst_q;
  logic [OP_W-1:0]  op_q;
  logic [LEN_W-1:0] left_q;

  assign accept    = req_valid && !busy_q;
  assign last      = busy_q && (left_q == LEN_W'(1));
  assign step_more = busy_q && !last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      src_q  <= '0;
      dst_q  <= '0;
      op_q   <= '0;
      left_q <= '0;
    end else begin
      done_q <= last;
      if (accept) begin
        busy_q <= 1'b1;
        src_q  <= src;
        dst_q  <= dst;
        op_q   <= op;
        left_q <= len;
      end else if (last) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        src_q  <= src_q + IDX_W'(1);
        dst_q  <= dst_q + IDX_W'(1);
        left_q <= left_q - LEN_W'(1);
      end
    end
  end

  assign busy    = busy_q;
  assign cur_src = src_q;
  assign cur_dst = dst_q;
  assign cur_op  = op_q;
  assign done    = done_q;

  // R2
  take_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  // R9
  finish_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (done && !busy));
  // R4
  stay_in_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_more |-> (cur_src[GRP_LOG2-1:0] != {GRP_LOG2{1'b1}}));
  // R8
  index_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_more |=> (busy && cur_src == $past(cur_src) + IDX_W'(1)
                   && cur_dst == $past(cur_dst) + IDX_W'(1) && $stable(cur_op)));
endmodule

// File: rtl/grp_ext_seq.sv
module grp_ext_seq
  import grp_seq_pkg::*;
#(
  parameter int         IDX_W    = 16,
  parameter int         OP_W     = 6,
  parameter logic [5:0] ADC_CODE = 6'h05,
  parameter logic [5:0] SBB_CODE = 6'h07
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [IDX_W-1:0] req_src,
  input  logic [IDX_W-1:0] req_dst,
  input  logic [OP_W-1:0]  req_op,
  input  logic             req_slot,
  input  logic [1:0]       req_ext_en,
  input  logic             req_cin,
  input  logic             alu_cout,
  output logic             busy,
  output logic             issue_valid,
  output logic [IDX_W-1:0] issue_src,
  output logic [IDX_W-1:0] issue_dst,
  output logic [OP_W-1:0]  issue_op,
  output logic             issue_cin,
  output logic             issue_last,
  output logic             done
);
  logic             fan_en;
  logic [LEN_W-1:0] len;
  logic             accept;
  logic             step_more;
  logic             busy_w;

  grp_span_calc #(.IDX_W(IDX_W), .NSLOT(2)) u_span (
    .clk    (clk),
    .rst_n  (rst_n),
    .src    (req_src),
    .dst    (req_dst),
    .slot   (req_slot),
    .ext_en (req_ext_en),
    .fan_en (fan_en),
    .len    (len)
  );

  grp_beat_ctrl #(.IDX_W(IDX_W), .OP_W(OP_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .src       (req_src),
    .dst       (req_dst),
    .op        (req_op),
    .len       (len),
    .accept    (accept),
    .busy      (busy_w),
    .cur_src   (issue_src),
    .cur_dst   (issue_dst),
    .cur_op    (issue_op),
    .last      (issue_last),
    .step_more (step_more),
    .done      (done)
  );

  grp_carry_link #(.OP_W(OP_W), .ADC_CODE(ADC_CODE), .SBB_CODE(SBB_CODE)) u_carry (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_cin  (req_cin),
    .op        (issue_op),
    .step_more (step_more),
    .alu_cout  (alu_cout),
    .cin       (issue_cin)
  );

  assign busy        = busy_w;
  assign issue_valid = busy_w;

  // R7
  slot_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fan_en == (req_slot ? req_ext_en[1] : req_ext_en[0])));
  // R2
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid && !issue_last) |=> (busy && issue_op == $past(issue_op)));
endmodule

// File: tb/grp_ext_seq_bench.sv
module grp_ext_seq_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [15:0] s;
    logic [15:0] d;
    logic [5:0]  op;
    logic        cin;
    logic        last;
  } beat_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_src = '0, req_dst = '0;
  logic [5:0]  req_op = '0;
  logic        req_slot = 1'b0;
  logic [1:0]  req_ext_en = '0;
  logic        req_cin = 1'b0;
  logic        alu_cout;
  logic        busy, issue_valid, issue_cin, issue_last, done;
  logic [15:0] issue_src, issue_dst;
  logic [5:0]  issue_op;

  int    total = 0, bad = 0, cyc = 0;
  bit    finished = 0;
  string cur_tag = "R1";
  beat_t q[$];
  bit    exp_done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // bench ALU carry-out: a fixed function of the beat's indices
  function automatic logic fake_cout(logic [15:0] s, logic [15:0] d);
    return s[0] ^ d[1];
  endfunction
  assign alu_cout = fake_cout(issue_src, issue_dst);

  grp_ext_seq u_grp_ext_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_src(req_src),
    .req_dst(req_dst), .req_op(req_op), .req_slot(req_slot),
    .req_ext_en(req_ext_en), .req_cin(req_cin), .alu_cout(alu_cout),
    .busy(busy), .issue_valid(issue_valid), .issue_src(issue_src),
    .issue_dst(issue_dst), .issue_op(issue_op), .issue_cin(issue_cin),
    .issue_last(issue_last), .done(done)
  );

  // Reference: on acceptance, list every beat the request must produce
  task automatic expand();
    int    n;
    bit    en;
    bit    chain;
    logic  c;
    beat_t b;
    en    = req_slot ? req_ext_en[1] : req_ext_en[0];
    chain = (req_op == 6'h05) || (req_op == 6'h07);
    n = 1;
    if (en && (req_src % 4 == req_dst % 4)) n = 4 - (req_src % 4);
    c = req_cin;
    for (int k = 0; k < n; k++) begin
      b.s = req_src + 16'(k);
      b.d = req_dst + 16'(k);
      b.op = req_op;
      b.cin = c;
      b.last = (k == n - 1);
      q.push_back(b);
      if (chain) c = fake_cout(b.s, b.d);
    end
  endtask

  always @(posedge clk) begin
    bit    was_busy;
    beat_t b;
    if (!rst_n) begin
      q.delete();
      exp_done = 0;
    end else begin
      was_busy = (q.size() != 0);
      exp_done = 0;
      if (was_busy) begin
        b = q.pop_front();
        exp_done = b.last;
      end
      if (req_valid && !was_busy) expand();
    end
  end

  // Compare every cycle, away from the rising edge
  always @(negedge clk) begin
    logic [42:0] act, exp_v;
    beat_t f;
    if (rst_n && !finished) begin
      act = {busy, issue_valid, issue_src, issue_dst, issue_op, issue_cin, issue_last, done};
      if (q.size() != 0) begin
        f = q[0];
        exp_v = {1'b1, 1'b1, f.s, f.d, f.op, f.cin, f.last, exp_done};
      end else begin
        exp_v = {1'b0, 1'b0, 16'h0, 16'h0, 6'h0, 1'b0, 1'b0, exp_done};
        act[40:3] = '0;  // beat fields are don't-care when idle
        act[2:1]  = {1'b0, issue_last};
      end
      total++;
      if (act !== exp_v) begin
        bad++;
        $display("FAIL %s cycle %0d actual=%h expected=%h", cur_tag, cyc, act, exp_v);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic set_req(logic [15:0] s, logic [15:0] d, logic [5:0] op,
                         logic slot, logic [1:0] en, logic cin);
    req_src = s; req_dst = d; req_op = op;
    req_slot = slot; req_ext_en = en; req_cin = cin;
  endtask

  task automatic pulse_req(logic [15:0] s, logic [15:0] d, logic [5:0] op,
                           logic slot, logic [1:0] en, logic cin);
    @(negedge clk);
    set_req(s, d, op, slot, en, cin);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (7) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state observed while still in reset
    total++;
    if ({busy, issue_valid, issue_last, done} !== 4'b0) begin
      bad++;
      $display("FAIL R1 actual=%b expected=0000", {busy, issue_valid, issue_last, done});
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    cur_tag = "R3";  pulse_req(16'h0010, 16'h0024, 6'h01, 1'b0, 2'b01, 1'b0); settle();
    cur_tag = "R4";  pulse_req(16'h0005, 16'h0009, 6'h02, 1'b0, 2'b01, 1'b0); settle();
                     pulse_req(16'h000A, 16'h0002, 6'h03, 1'b0, 2'b01, 1'b0); settle();
                     pulse_req(16'h000F, 16'h0013, 6'h04, 1'b0, 2'b01, 1'b0); settle();
    cur_tag = "R5";  pulse_req(16'h0004, 16'h000A, 6'h01, 1'b0, 2'b11, 1'b0); settle();
                     pulse_req(16'h0101, 16'h0203, 6'h01, 1'b1, 2'b11, 1'b0); settle();
    cur_tag = "R6";  pulse_req(16'h0008, 16'h000C, 6'h01, 1'b0, 2'b10, 1'b0); settle();
    cur_tag = "R7";  pulse_req(16'h0020, 16'h0030, 6'h01, 1'b1, 2'b10, 1'b0); settle();
                     pulse_req(16'h0020, 16'h0030, 6'h01, 1'b0, 2'b10, 1'b0); settle();
                     pulse_req(16'h0040, 16'h0050, 6'h01, 1'b1, 2'b01, 1'b0); settle();
    cur_tag = "R10"; pulse_req(16'h0041, 16'h0045, 6'h05, 1'b0, 2'b01, 1'b1); settle();
                     pulse_req(16'h0060, 16'h0074, 6'h07, 1'b1, 2'b10, 1'b0); settle();
                     pulse_req(16'h0080, 16'h0094, 6'h01, 1'b0, 2'b01, 1'b1); settle();

    // R2: a second request raised for one cycle while busy is dropped
    cur_tag = "R2";
    pulse_req(16'h0100, 16'h0200, 6'h05, 1'b0, 2'b01, 1'b0);
    set_req(16'h0300, 16'h0400, 6'h09, 1'b0, 2'b01, 1'b1);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    settle();

    // R9: hold the next request so it is taken in the done cycle
    cur_tag = "R9";
    pulse_req(16'h0500, 16'h0600, 6'h01, 1'b0, 2'b01, 1'b0);
    set_req(16'h0702, 16'h0806, 6'h05, 1'b1, 2'b10, 1'b1);
    req_valid = 1'b1;
    while (busy) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    settle();
    cur_tag = "R8";  pulse_req(16'hFFFC, 16'h0000, 6'h3F, 1'b0, 2'b01, 1'b0); settle();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule